// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous single-port static memory whose data bus never needs an idle cycle when it changes direction between reads and writes. Every control and address input is sampled on the rising clock edge. A read presents its word from an output register. A write takes its data two active edges after its command. A read and a write therefore use the bus in the same relative slot, and commands of either type can be issued on every cycle in any order.

A write's data arrives late, so the address, type and lane enables of each write move through two stages of a write queue before the word is stored. A read that targets a word whose write is still in that queue gets the queued bytes, merged lane by lane with the stored word. Commands can also come from an internal two-bit burst counter: an advance cycle repeats the type of the last load and steps the low two address bits in linear or XOR order. A clock enable freezes the whole pipeline. An asynchronous output enable gates only the drive of the read data. The bidirectional bus is modelled as separate input, output and drive-enable signals.

Top module: `turnless_sram`

## Requirements
- R1: While reset is asserted and directly after it is released, `dq_oe` is low and no read or write is pending.
- R2: A read loaded at active edge k drives the stored word on `dq_out` from edge k+1 until the next active edge. It is sampled at edge k+2, and `dq_oe` is high for that slot when `oe_n` is low.
- R3: The data of a write loaded at active edge k is taken from `dq_in` at the second active edge after k. Lane i is bits [8i+7:8i], and only lanes whose `bw_n[i]` was low with the command are updated. With all `bw_n` bits high, nothing changes.
- R4: Reads and writes to any addresses can alternate on consecutive cycles with no idle cycle, and each read returns the data of all earlier writes.
- R5: A read issued one or two cycles after a write to the same address returns the new bytes in the lanes that write enabled and the older contents in the other lanes. Where two pending writes overlap, the younger write wins.
- R6: `dq_oe` is low in every bus slot that belongs to a write, a deselect or a suspended start-up slot.
- R7: `dq_oe` is low whenever `oe_n` is high, and it follows `oe_n` without waiting for a clock edge. `dq_out` still holds the read word.
- R8: A load (`adv_ld` low) is accepted only when `en0_n` is low, `en1` is high and `en2_n` is low. Otherwise the cycle is a deselect that neither reads nor writes.
- R9: While `cen_n` is high, no state changes: `dq_out` and `dq_oe` hold, and the command, address and data inputs are ignored.
- R10: An advance cycle (`adv_ld` high) repeats the type of the last load, keeps its upper address bits and ignores the chip enables, `we_n` and `addr`. An advance after a deselect is again a deselect.
- R11: After n advances since a load with start low bits s, the low two address bits are (s+n) mod 4 when `mode` was 0 at the load (linear), or s XOR (n mod 4) when `mode` was 1 (interleaved).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable; high suspends all operation |
| en0_n | input | 1 | Active-low chip enable |
| en1 | input | 1 | Active-high chip enable |
| en2_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write command, sampled on a load |
| bw_n | input | BYTES (4) | Active-low lane write selects, sampled with each command |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | ADDR_W (6) | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | BYTES*BYTE_W (32) | Write data from the bus |
| dq_out | output | BYTES*BYTE_W (32) | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable for `dq_out` |

## Verification
Isolated writes and reads spaced apart show the plain storage path and the two-slot timing. Strict read/write alternation and a read placed right after two overlapping partial writes tell a correct forward from a read that only sees the array, and show which pending write wins each lane. Bursts in both orders, one of them wrapping through the upper half of a four-word group, separate linear stepping from XOR stepping. Deselects made through each chip enable, an advance after a deselect, a suspended clock carrying a conflicting write, and output enable toggled mid-slot show that each control blocks only what it should.

// File: rtl/turnless_pkg.sv
package turnless_pkg;

   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } burst_ord_e;

   // low address bits for the n-th beat of a burst starting at start
   function automatic logic [1:0] burst_low(burst_ord_e ord, logic [1:0] start, logic [1:0] n);
      logic [1:0] r;
      case (ord)
         ORD_XOR: r = start ^ n;
         default: r = start + n;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/turnless_burst.sv
module turnless_burst
   import turnless_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cken,
   input  logic              adv_ld,
   input  logic              sel,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [BYTES-1:0]  be_in,
   input  logic              mode_in,
   output logic              s1_valid,
   output logic              s1_wr,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [BYTES-1:0]  s1_be
);

   localparam int HI = ADDR_W - 1;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("turnless_burst: ADDR_W must be at least 3");
   end

   logic              run_valid;
   logic              run_wr;
   logic [ADDR_W-1:0] run_base;
   logic [1:0]        run_cnt;
   burst_ord_e        run_ord;

   logic [1:0]        step_cnt;
   logic              nxt_valid;
   logic              nxt_wr;
   logic [ADDR_W-1:0] nxt_addr;

   assign step_cnt = run_cnt + 2'd1;

   always_comb begin
      if (!adv_ld) begin
         nxt_valid = sel;
         nxt_wr    = wr_req;
         nxt_addr  = addr_in;
      end else begin
         nxt_valid = run_valid;
         nxt_wr    = run_wr;
         nxt_addr  = {run_base[HI:2], burst_low(run_ord, run_base[1:0], step_cnt)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_valid <= 1'b0;
         run_wr    <= 1'b0;
         run_base  <= '0;
         run_cnt   <= 2'd0;
         run_ord   <= ORD_LINEAR;
         s1_valid  <= 1'b0;
         s1_wr     <= 1'b0;
         s1_addr   <= '0;
         s1_be     <= '0;
      end else if (cken) begin
         if (!adv_ld) begin
            run_valid <= sel;
            run_wr    <= wr_req;
            run_base  <= addr_in;
            run_cnt   <= 2'd0;
            run_ord   <= burst_ord_e'(mode_in);
         end else begin
            run_cnt   <= step_cnt;
         end
         s1_valid <= nxt_valid;
         s1_wr    <= nxt_wr;
         s1_addr  <= nxt_addr;
         s1_be    <= be_in;
      end
   end

   // R8: a load without all three enables issues nothing
   a_r8_deselect_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (cken && !adv_ld && !sel) |=> !s1_valid);

   // R10: an advance keeps the upper bits of the issued address
   a_r10_high_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cken && adv_ld && run_valid) |=> (s1_addr[HI:2] == $past(s1_addr[HI:2])));

   // R11: in linear order each advance steps the previous issued low bits by one
   a_r11_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cken && adv_ld && run_valid && run_ord == ORD_LINEAR)
      |=> (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1));

endmodule

// File: rtl/turnless_array.sv
module turnless_array #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      cken,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [BYTES-1:0]          wbe,
   input  logic [BYTES*BYTE_W-1:0]   wdata,
   input  logic [ADDR_W-1:0]         raddr,
   output logic [BYTES*BYTE_W-1:0]   rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   if (DEPTH * BYTES > 4096) begin : g_bad_size
      $error("turnless_array: array too large for this model");
   end

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic [BYTE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (cken && wr_en && wbe[g])
            cells[waddr] <= wdata[g*BYTE_W +: BYTE_W];
      end

      assign rdata[g*BYTE_W +: BYTE_W] = cells[raddr];
   end

endmodule

// File: rtl/turnless_wrbuf.sv
module turnless_wrbuf #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cken,
   input  logic                      s1_valid,
   input  logic                      s1_wr,
   input  logic [ADDR_W-1:0]         s1_addr,
   input  logic [BYTES-1:0]          s1_be,
   input  logic [BYTES*BYTE_W-1:0]   din,
   input  logic [BYTES*BYTE_W-1:0]   mem_rd,
   output logic                      cm_valid,
   output logic [ADDR_W-1:0]         cm_addr,
   output logic [BYTES-1:0]          cm_be,
   output logic [BYTES*BYTE_W-1:0]   cm_data,
   output logic [BYTES*BYTE_W-1:0]   fwd_word,
   output logic                      slot_wr
);

   localparam int DATA_W = BYTES * BYTE_W;

   // stage 2: write waiting for its data on the bus
   logic              s2_v;
   logic [ADDR_W-1:0] s2_addr;
   logic [BYTES-1:0]  s2_be;
   // stage 3: write holding its data, stored at the next active edge
   logic              s3_v;
   logic [ADDR_W-1:0] s3_addr;
   logic [BYTES-1:0]  s3_be;
   logic [DATA_W-1:0] s3_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v    <= 1'b0;
         s2_addr <= '0;
         s2_be   <= '0;
         s3_v    <= 1'b0;
         s3_addr <= '0;
         s3_be   <= '0;
         s3_data <= '0;
      end else if (cken) begin
         s2_v    <= s1_valid & s1_wr;
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
         s3_v    <= s2_v;
         s3_addr <= s2_addr;
         s3_be   <= s2_be;
         s3_data <= din;
      end
   end

   logic hit2, hit3;
   assign hit2 = s2_v && (s2_addr == s1_addr);
   assign hit3 = s3_v && (s3_addr == s1_addr);

   // per lane: younger pending write first, then older, then the array
   for (genvar g = 0; g < BYTES; g++) begin : g_merge
      always_comb begin
         if (hit2 && s2_be[g])
            fwd_word[g*BYTE_W +: BYTE_W] = din[g*BYTE_W +: BYTE_W];
         else if (hit3 && s3_be[g])
            fwd_word[g*BYTE_W +: BYTE_W] = s3_data[g*BYTE_W +: BYTE_W];
         else
            fwd_word[g*BYTE_W +: BYTE_W] = mem_rd[g*BYTE_W +: BYTE_W];
      end
   end

   assign cm_valid = s3_v;
   assign cm_addr  = s3_addr;
   assign cm_be    = s3_be;
   assign cm_data  = s3_data;
   assign slot_wr  = s2_v;

endmodule

// File: rtl/turnless_sram.sv
module turnless_sram #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4,
   parameter int BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cen_n,
   input  logic                      en0_n,
   input  logic                      en1,
   input  logic                      en2_n,
   input  logic                      we_n,
   input  logic [BYTES-1:0]          bw_n,
   input  logic                      adv_ld,
   input  logic                      mode,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      oe_n,
   input  logic [BYTES*BYTE_W-1:0]   dq_in,
   output logic [BYTES*BYTE_W-1:0]   dq_out,
   output logic                      dq_oe
);

   localparam int DATA_W = BYTES * BYTE_W;

   if (BYTES < 1 || BYTE_W < 1) begin : g_bad_lanes
      $error("turnless_sram: BYTES and BYTE_W must be positive");
   end

   logic cken, sel;
   assign cken = ~cen_n;
   assign sel  = ~en0_n & en1 & ~en2_n;

   logic              s1_valid, s1_wr;
   logic [ADDR_W-1:0] s1_addr;
   logic [BYTES-1:0]  s1_be;

   turnless_burst #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .cken     (cken),
      .adv_ld   (adv_ld),
      .sel      (sel),
      .wr_req   (~we_n),
      .addr_in  (addr),
      .be_in    (~bw_n),
      .mode_in  (mode),
      .s1_valid (s1_valid),
      .s1_wr    (s1_wr),
      .s1_addr  (s1_addr),
      .s1_be    (s1_be)
   );

   logic              cm_valid;
   logic [ADDR_W-1:0] cm_addr;
   logic [BYTES-1:0]  cm_be;
   logic [DATA_W-1:0] cm_data;
   logic [DATA_W-1:0] mem_rd;
   logic [DATA_W-1:0] fwd_word;
   logic              slot_wr;

   turnless_wrbuf #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_wrbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .cken     (cken),
      .s1_valid (s1_valid),
      .s1_wr    (s1_wr),
      .s1_addr  (s1_addr),
      .s1_be    (s1_be),
      .din      (dq_in),
      .mem_rd   (mem_rd),
      .cm_valid (cm_valid),
      .cm_addr  (cm_addr),
      .cm_be    (cm_be),
      .cm_data  (cm_data),
      .fwd_word (fwd_word),
      .slot_wr  (slot_wr)
   );

   turnless_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
      .clk   (clk),
      .cken  (cken),
      .wr_en (cm_valid),
      .waddr (cm_addr),
      .wbe   (cm_be),
      .wdata (cm_data),
      .raddr (s1_addr),
      .rdata (mem_rd)
   );

   logic              rd_valid_q;
   logic [DATA_W-1:0] dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         dout_q     <= '0;
      end else if (cken) begin
         rd_valid_q <= s1_valid & ~s1_wr;
         if (s1_valid && !s1_wr)
            dout_q <= fwd_word;
      end
   end

   assign dq_out = dout_q;
   assign dq_oe  = rd_valid_q & ~oe_n;

   // R6: a read slot and a write data slot never coincide on the bus
   a_r6_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid_q && slot_wr));

   // R9: a suspended edge leaves the output register untouched
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cken) |=> ($stable(dout_q) && $stable(rd_valid_q)));

endmodule

// File: tb/sim_turnless_sram.sv
`timescale 1ns/1ps
module sim_turnless_sram;

   localparam int AW = 6;
   localparam int NB = 4;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n;
   logic cen_n, en0_n, en1, en2_n, we_n, adv_ld, mode, oe_n;
   logic [NB-1:0] bw_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_in;
   logic [DW-1:0] dq_out;
   logic dq_oe;

   always #4 clk = ~clk;

   turnless_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .en0_n(en0_n), .en1(en1),
      .en2_n(en2_n), .we_n(we_n), .bw_n(bw_n), .adv_ld(adv_ld), .mode(mode),
      .addr(addr), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   // bench model
   logic [DW-1:0] mem_m [0:(1<<AW)-1];
   bit            b_valid = 0, b_wr = 0, b_ord = 0;
   logic [AW-1:0] b_base = '0;
   logic [1:0]    b_cnt = '0;
   int            q_kind [0:1];   // 0 none, 1 read, 2 write
   logic [DW-1:0] q_data [0:1];
   string         q_tag  [0:1];
   int            dsel_pin = 1;   // which enable a deselect drops

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input bit cen, input bit adv, input bit sel, input bit we,
                      input logic [AW-1:0] a, input logic [NB-1:0] bwn, input bit md,
                      input logic [DW-1:0] wd, input bit oen, input string tag);
      int kind;
      logic [AW-1:0] ca;
      logic [DW-1:0] dat;
      @(negedge clk);
      cen_n  = ~cen;
      adv_ld = adv;
      en0_n  = (!sel && dsel_pin == 0);
      en1    = !(!sel && dsel_pin == 1);
      en2_n  = (!sel && dsel_pin == 2);
      we_n   = ~we;
      addr   = a;
      bw_n   = bwn;
      mode   = md;
      oe_n   = oen;
      dq_in  = (q_kind[1] == 2) ? q_data[1] : 32'hC3C3_5A5A;
      #1;
      if (q_kind[1] == 1) begin
         chk(dq_oe == !oen, oen ? "R7" : q_tag[1], "dq_oe in read slot", {31'd0, dq_oe}, {31'd0, !oen});
         chk(dq_out == q_data[1], q_tag[1], "read data", dq_out, q_data[1]);
      end else begin
         chk(dq_oe == 1'b0, "R6", "dq_oe in non-read slot", {31'd0, dq_oe}, 32'd0);
      end
      if (cen) begin
         kind = 0; ca = a; dat = '0;
         if (!adv) begin
            b_valid = sel; b_wr = we; b_base = a; b_cnt = 2'd0; b_ord = md;
            ca = a;
         end else begin
            b_cnt = b_cnt + 2'd1;
            ca = {b_base[AW-1:2], b_ord ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
         end
         if (b_valid) begin
            if (b_wr) begin
               kind = 2; dat = wd;
               for (int i = 0; i < NB; i++)
                  if (!bwn[i]) mem_m[ca][i*8 +: 8] = wd[i*8 +: 8];
            end else begin
               kind = 1; dat = mem_m[ca];
            end
         end
         q_kind[1] = q_kind[0]; q_data[1] = q_data[0]; q_tag[1] = q_tag[0];
         q_kind[0] = kind;      q_data[0] = dat;       q_tag[0] = tag;
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] bwn, input string tag);
      cyc(1, 0, 1, 1, a, bwn, 0, d, 0, tag);
   endtask
   task automatic rd(input logic [AW-1:0] a, input string tag);
      cyc(1, 0, 1, 0, a, 4'hF, 0, '0, 0, tag);
   endtask
   task automatic idle(input string tag);
      cyc(1, 0, 0, 0, '0, 4'hF, 0, '0, 0, tag);
   endtask
   task automatic flush();
      for (int i = 0; i < 3; i++) idle("R6");
   endtask

   task automatic test_reset();
      rst_n = 0; cen_n = 0; en0_n = 1; en1 = 0; en2_n = 1; we_n = 1; adv_ld = 0;
      mode = 0; oe_n = 0; bw_n = '1; addr = '0; dq_in = '0;
      q_kind[0] = 0; q_kind[1] = 0; q_data[0] = '0; q_data[1] = '0;
      q_tag[0] = "R1"; q_tag[1] = "R1";
      repeat (3) @(posedge clk);
      #1 chk(dq_oe == 1'b0, "R1", "dq_oe in reset", {31'd0, dq_oe}, 32'd0);
      @(negedge clk) rst_n = 1;
      #1 chk(dq_oe == 1'b0, "R1", "dq_oe after reset", {31'd0, dq_oe}, 32'd0);
      flush();
   endtask

   task automatic test_basic();
      wr(6'h10, 32'h1122_3344, 4'h0, "R3");
      idle("R3"); idle("R3"); idle("R3");
      rd(6'h10, "R2");
      wr(6'h11, 32'hA5A5_0F0F, 4'h0, "R3");
      flush();
      rd(6'h11, "R2");
      flush();
   endtask

   task automatic test_b2b();
      wr(6'h01, 32'h0000_0101, 4'h0, "R4");
      rd(6'h10, "R4");
      wr(6'h02, 32'h0000_0202, 4'h0, "R4");
      rd(6'h01, "R4");
      wr(6'h03, 32'h0000_0303, 4'h0, "R4");
      rd(6'h02, "R4");
      rd(6'h03, "R4");
      wr(6'h01, 32'hFFFF_0001, 4'h0, "R4");
      wr(6'h02, 32'hFFFF_0002, 4'h0, "R4");
      rd(6'h01, "R4");
      rd(6'h02, "R4");
      flush();
   endtask

   task automatic test_coherency();
      wr(6'h20, 32'h1111_1111, 4'h0, "R5");
      flush();
      wr(6'h20, 32'hAAAA_AAAA, 4'b1100, "R5");   // lanes 0,1
      wr(6'h20, 32'hBBBB_BBBB, 4'b1010, "R5");   // lanes 0,2 (younger)
      rd(6'h20, "R5");
      rd(6'h20, "R5");
      wr(6'h21, 32'h0102_0304, 4'h0, "R5");
      idle("R5");
      rd(6'h21, "R5");
      flush();
      rd(6'h20, "R5");
      flush();
   endtask

   task automatic test_bytes();
      wr(6'h10, 32'hDEAD_BEEF, 4'hF, "R3");      // no lane selected
      wr(6'h11, 32'h7777_7777, 4'b0111, "R3");   // lane 3 only
      flush();
      rd(6'h10, "R3");
      rd(6'h11, "R3");
      flush();
   endtask

   task automatic test_deselect();
      for (int p = 0; p < 3; p++) begin
         dsel_pin = p;
         cyc(1, 0, 0, 1, 6'h10, 4'h0, 0, 32'h0BAD_0BAD, 0, "R8");
         flush();
         rd(6'h10, "R8");
         flush();
      end
      dsel_pin = 1;
      // advance after a deselect stays deselected
      cyc(1, 0, 0, 1, 6'h10, 4'h0, 0, 32'h0BAD_0BAD, 0, "R10");
      cyc(1, 1, 1, 1, 6'h10, 4'h0, 0, 32'h0BAD_0BAD, 0, "R10");
      cyc(1, 1, 1, 0, 6'h11, 4'h0, 0, 32'h0BAD_0BAD, 0, "R10");
      flush();
      rd(6'h10, "R10");
      rd(6'h11, "R10");
      flush();
   endtask

   task automatic test_oe();
      rd(6'h21, "R7");
      idle("R7");
      cyc(1, 0, 0, 0, '0, 4'hF, 0, '0, 1, "R7");  // read slot with oe_n high
      oe_n = 0;
      #1 chk(dq_oe == 1'b1, "R7", "dq_oe after async oe_n fall", {31'd0, dq_oe}, 32'd1);
      oe_n = 1;
      #1 chk(dq_oe == 1'b0, "R7", "dq_oe after async oe_n rise", {31'd0, dq_oe}, 32'd0);
      flush();
   endtask

   task automatic test_stall();
      rd(6'h10, "R9");
      idle("R9");
      for (int i = 0; i < 3; i++)
         cyc(0, 0, 1, 1, 6'h10, 4'h0, 0, 32'hFEED_FACE, 0, "R9");
      idle("R9");
      // write pending across a stall keeps its data slot
      wr(6'h12, 32'h1234_5678, 4'h0, "R9");
      cyc(0, 0, 1, 1, 6'h12, 4'h0, 0, 32'h0, 0, "R9");
      cyc(0, 0, 1, 0, 6'h12, 4'h0, 0, 32'h0, 0, "R9");
      idle("R9");
      rd(6'h12, "R9");
      rd(6'h10, "R9");
      flush();
   endtask

   task automatic test_burst();
      // linear write burst from low bits 2: 0E,0F,0C,0D
      cyc(1, 0, 1, 1, 6'h0E, 4'h0, 0, 32'hB000_0000, 0, "R11");
      cyc(1, 1, 0, 0, 6'h00, 4'h0, 1, 32'hB000_0001, 0, "R11");
      cyc(1, 1, 0, 0, 6'h00, 4'h0, 1, 32'hB000_0002, 0, "R11");
      cyc(1, 1, 0, 0, 6'h00, 4'h0, 1, 32'hB000_0003, 0, "R11");
      flush();
      rd(6'h0C, "R11"); rd(6'h0D, "R11"); rd(6'h0E, "R11"); rd(6'h0F, "R11");
      flush();
      // interleaved write burst from low bits 1: 31,30,33,32
      cyc(1, 0, 1, 1, 6'h31, 4'h0, 1, 32'hC000_0000, 0, "R11");
      cyc(1, 1, 1, 0, 6'h00, 4'h0, 0, 32'hC000_0001, 0, "R11");
      cyc(1, 1, 1, 0, 6'h00, 4'h0, 0, 32'hC000_0002, 0, "R11");
      cyc(1, 1, 1, 0, 6'h00, 4'h0, 0, 32'hC000_0003, 0, "R11");
      flush();
      rd(6'h30, "R11"); rd(6'h31, "R11"); rd(6'h32, "R11"); rd(6'h33, "R11");
      flush();
      // read bursts: linear from 0D wraps through 0E,0F,0C; interleaved from 32
      cyc(1, 0, 1, 0, 6'h0D, 4'hF, 0, '0, 0, "R10");
      for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1, 6'h3F, 4'h0, 1, '0, 0, "R10");
      cyc(1, 0, 1, 0, 6'h32, 4'hF, 1, '0, 0, "R11");
      for (int i = 0; i < 3; i++) cyc(1, 1, 0, 1, 6'h00, 4'h0, 0, '0, 0, "R11");
      flush();
   endtask

   initial begin
      test_reset();
      test_basic();
      test_b2b();
      test_coherency();
      test_bytes();
      test_deselect();
      test_oe();
      test_stall();
      test_burst();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule